// File: doc/BRIEF.md
# Mode-Configurable Three-Channel Line Delay Memory

This block holds three FIFO-style delay channels, A, B and C, each with its own write side (clock, pointer reset, enable, data) and read side (clock, pointer reset, enable, output enable, data). Each pointer returns to address zero when its reset is asserted, so the delay a channel gives is set by the spacing between the write-reset and read-reset events. Video and image pipelines use it to keep one or more earlier lines or fields next to the live stream.

A static 3-bit `mode` input rearranges the same storage. The channels can run as three independent 8-bit delays. They can be chained so that one input yields several outputs at once, each delayed by a further line. They can also be widened to 12 bits by giving each of A and B one 4-bit half of C. In a chained stage, both the write side and the read side run from the first stage's read clock, read reset and read enable. Each chained stage stores the word that the stage before it reads on that same edge.

Top module: `line_delay_mem`

## Requirements
- R1: With `mode` = 1, channels A, B and C are independent 8-bit delays. Each one stores `din_x` on its own write side and returns it on `q_x` through its own read side, and a channel whose read reset is held never changes its output.
- R2: On a clock edge of a port whose reset is high, that port's pointer becomes 0 and no word is written or read at that edge. A read of an address on the same edge that writes it returns the older word.
- R3: On a write-clock edge with the write reset low and the write enable low, nothing is stored and the write pointer holds.
- R4: On a read-clock edge with the read reset low and the read enable low, the read pointer holds and the channel output keeps its last value.
- R5: Each pointer moves to the next address on every enabled edge and goes from DEPTH-1 back to 0, so a write past the end overwrites address 0.
- R6: With `mode` = 2, A takes `din_a`, and B and C are chained behind it. `q_a`, `q_b` and `q_c` then carry the stream delayed by one, two and three lines.
- R7: With `mode` = 3, B is chained behind A, so `q_a` is one line late and `q_b` is two lines late. Channel C stays independent.
- R8: With `mode` = 4 there are two independent 12-bit channels. The first stores {`din_c[7:4]`, `din_a`} under A's controls and returns it on {`q_c[7:4]`, `q_a`}. The second stores {`din_c[3:0]`, `din_b`} under B's controls and returns it on {`q_c[3:0]`, `q_b`}.
- R9: With `mode` = 5, the second 12-bit channel is chained behind the first, which takes its 12-bit input as in R8. {`q_c[7:4]`, `q_a`} is then one line late and {`q_c[3:0]`, `q_b`} is two lines late.
- R10: In every chained mode, a downstream stage writes the word the stage ahead of it reads on the same `rclk_a` edge, under `rrst_a` and `ren_a`. Its own clock, reset and enable pins have no effect.
- R11: A low output enable forces its output data to zero and drops its drive flag. In modes 4 and 5, `q_c[7:4]` follows `oe_a` and `q_c[3:0]` follows `oe_b`. In the other modes both halves follow `oe_c`.
- R12: `mode` codes other than 2 to 5 behave exactly as `mode` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 3 | Configuration code, changed only while all resets are high |
| wclk_a | input | 1 | Channel A write clock |
| wrst_a | input | 1 | Channel A write pointer reset |
| wen_a | input | 1 | Channel A write enable |
| din_a | input | 8 | Channel A write data |
| rclk_a | input | 1 | Channel A read clock, also drives chained stages |
| rrst_a | input | 1 | Channel A read pointer reset |
| ren_a | input | 1 | Channel A read enable |
| oe_a | input | 1 | Channel A output enable |
| q_a | output | 8 | Channel A read data |
| q_a_on | output | 1 | Channel A drive flag |
| wclk_b | input | 1 | Channel B write clock |
| wrst_b | input | 1 | Channel B write pointer reset |
| wen_b | input | 1 | Channel B write enable |
| din_b | input | 8 | Channel B write data |
| rclk_b | input | 1 | Channel B read clock |
| rrst_b | input | 1 | Channel B read pointer reset |
| ren_b | input | 1 | Channel B read enable |
| oe_b | input | 1 | Channel B output enable |
| q_b | output | 8 | Channel B read data |
| q_b_on | output | 1 | Channel B drive flag |
| wclk_c | input | 1 | Channel C write clock |
| wrst_c | input | 1 | Channel C write pointer reset |
| wen_c | input | 1 | Channel C write enable |
| din_c | input | 8 | Channel C write data, split into halves in 12-bit modes |
| rclk_c | input | 1 | Channel C read clock |
| rrst_c | input | 1 | Channel C read pointer reset |
| ren_c | input | 1 | Channel C read enable |
| oe_c | input | 1 | Channel C output enable |
| q_c | output | 8 | Channel C read data |
| q_c_on | output | 2 | Drive flags for the upper and lower halves of `q_c` |

## Verification
A wrong pointer shows up at the ports as a word from the wrong address, one read edge after the fault. If the fault is a missed wrap, a word returns from the wrong line in the next line period. Control routed to the wrong source in a chained or widened mode shows up as a nibble of a different channel, or as a nibble that stops changing. That appears on the first read of a line in which the affected stage is compared, which is within one to three line periods. Routing errors in the output enable can be seen in the same cycle as the enable change.

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic [2:0]    mode,
  input  logic          wclk_a,
  input  logic          wrst_a,
  input  logic          wen_a,
  input  logic [DW-1:0] din_a,
  input  logic          rclk_a,
  input  logic          rrst_a,
  input  logic          ren_a,
  input  logic          oe_a,
  output logic [DW-1:0] q_a,
  output logic          q_a_on,
  input  logic          wclk_b,
  input  logic          wrst_b,
  input  logic          wen_b,
  input  logic [DW-1:0] din_b,
  input  logic          rclk_b,
  input  logic          rrst_b,
  input  logic          ren_b,
  input  logic          oe_b,
  output logic [DW-1:0] q_b,
  output logic          q_b_on,
  input  logic          wclk_c,
  input  logic          wrst_c,
  input  logic          wen_c,
  input  logic [DW-1:0] din_c,
  input  logic          rclk_c,
  input  logic          rrst_c,
  input  logic          ren_c,
  input  logic          oe_c,
  output logic [DW-1:0] q_c,
  output logic [1:0]    q_c_on
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HW = DW / 2;
  localparam int NL = 6;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [2:0] wck_p, wrs_p, wen_p, rck_p, rrs_p, ren_p;
  logic [DW-1:0] din_p [3];
  assign wck_p = {wclk_c, wclk_b, wclk_a};
  assign wrs_p = {wrst_c, wrst_b, wrst_a};
  assign wen_p = {wen_c, wen_b, wen_a};
  assign rck_p = {rclk_c, rclk_b, rclk_a};
  assign rrs_p = {rrst_c, rrst_b, rrst_a};
  assign ren_p = {ren_c, ren_b, ren_a};
  assign din_p[0] = din_a;
  assign din_p[1] = din_b;
  assign din_p[2] = din_c;

  logic m2, m3, m4, m5, wide;
  logic [NL-1:0] casc;
  assign m2   = (mode == 3'd2);
  assign m3   = (mode == 3'd3);
  assign m4   = (mode == 3'd4);
  assign m5   = (mode == 3'd5);
  assign wide = m4 | m5;
  assign casc = m2 ? 6'b111100 : m3 ? 6'b001100 : m5 ? 6'b011100 : 6'b000000;

  logic [NL-1:0] lw_ck, lw_rs, lw_en, lr_ck, lr_rs, lr_en;
  logic [HW-1:0] lw_d [NL];
  logic [HW-1:0] rnow [NL];
  logic [HW-1:0] rq_v [NL];
  logic [AW-1:0] wp_v [NL];
  logic [AW-1:0] rp_v [NL];

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      lw_ck[i] = wck_p[i/2];
      lw_rs[i] = wrs_p[i/2];
      lw_en[i] = wen_p[i/2];
      lr_ck[i] = rck_p[i/2];
      lr_rs[i] = rrs_p[i/2];
      lr_en[i] = ren_p[i/2];
      lw_d[i]  = din_p[i/2][(i%2)*HW +: HW];
    end
    if (wide) begin
      lw_ck[5] = wck_p[0]; lw_rs[5] = wrs_p[0]; lw_en[5] = wen_p[0];
      lr_ck[5] = rck_p[0]; lr_rs[5] = rrs_p[0]; lr_en[5] = ren_p[0];
      lw_ck[4] = wck_p[1]; lw_rs[4] = wrs_p[1]; lw_en[4] = wen_p[1];
      lr_ck[4] = rck_p[1]; lr_rs[4] = rrs_p[1]; lr_en[4] = ren_p[1];
    end
    for (int i = 2; i < NL; i++) begin
      if (casc[i]) begin
        lw_ck[i] = rck_p[0]; lw_rs[i] = rrs_p[0]; lw_en[i] = ren_p[0];
        lr_ck[i] = rck_p[0]; lr_rs[i] = rrs_p[0]; lr_en[i] = ren_p[0];
        lw_d[i]  = rnow[(m5 && i == 4) ? 5 : i - 2];
      end
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [HW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [HW-1:0] rq;
    logic wc, rc;
    assign wc = lw_ck[g];
    assign rc = lr_ck[g];

    always_ff @(posedge wc) begin
      if (lw_rs[g]) begin
        wp <= '0;
      end else if (lw_en[g]) begin
        mem[wp] <= lw_d[g];
        wp      <= (wp == LAST) ? '0 : wp + 1'b1;
      end
    end

    always_ff @(posedge rc) begin
      if (lr_rs[g]) begin
        rp <= '0;
      end else if (lr_en[g]) begin
        rq <= mem[rp];
        rp <= (rp == LAST) ? '0 : rp + 1'b1;
      end
    end

    assign wp_v[g] = wp;
    assign rp_v[g] = rp;
    assign rq_v[g] = rq;
    assign rnow[g] = mem[rp];
  end

  logic oe_hi, oe_lo;
  assign oe_hi  = wide ? oe_a : oe_c;
  assign oe_lo  = wide ? oe_b : oe_c;
  assign q_a    = oe_a ? {rq_v[1], rq_v[0]} : '0;
  assign q_b    = oe_b ? {rq_v[3], rq_v[2]} : '0;
  assign q_c    = {oe_hi ? rq_v[5] : {HW{1'b0}}, oe_lo ? rq_v[4] : {HW{1'b0}}};
  assign q_a_on = oe_a;
  assign q_b_on = oe_b;
  assign q_c_on = {oe_hi, oe_lo};
endmodule

// File: rtl/line_delay_mem_chk.sv
module line_delay_mem_chk #(
  parameter int AW    = 4,
  parameter int DEPTH = 16,
  parameter int HW    = 4
) (
  input logic [2:0]    mode,
  input logic          wclk_a,
  input logic          wrst_a,
  input logic          wen_a,
  input logic          rclk_a,
  input logic          rrst_a,
  input logic          ren_a,
  input logic [AW-1:0] wp0,
  input logic [AW-1:0] rp0,
  input logic [AW-1:0] wp4,
  input logic [AW-1:0] rp4,
  input logic [HW-1:0] rq0
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic warm = 1'b0;
  logic rarm = 1'b0;
  always_ff @(posedge wclk_a) if (wrst_a) warm <= 1'b1;
  always_ff @(posedge rclk_a) if (rrst_a) rarm <= 1'b1;

  // R3
  wen_hold_chk: assert property (@(posedge wclk_a) disable iff (!warm)
    (!wrst_a && !wen_a) |=> $stable(wp0));

  // R2
  rrst_zero_chk: assert property (@(posedge rclk_a) disable iff (!rarm)
    rrst_a |=> (rp0 == '0));

  // R5
  rptr_wrap_chk: assert property (@(posedge rclk_a) disable iff (!rarm)
    (!rrst_a && ren_a && rp0 == LAST) |=> (rp0 == '0));

  // R4
  read_hold_chk: assert property (@(posedge rclk_a) disable iff (!rarm)
    (!rrst_a && !ren_a) |=> ($stable(rp0) && $stable(rq0)));

  // R10
  casc_reset_chk: assert property (@(posedge rclk_a) disable iff (!rarm)
    (mode == 3'd2 && rrst_a) |=> (wp4 == '0 && rp4 == '0));
endmodule

bind line_delay_mem line_delay_mem_chk #(.AW(AW), .DEPTH(DEPTH), .HW(HW)) u_chk (
  .mode(mode), .wclk_a(wclk_a), .wrst_a(wrst_a), .wen_a(wen_a),
  .rclk_a(rclk_a), .rrst_a(rrst_a), .ren_a(ren_a),
  .wp0(wp_v[0]), .rp0(rp_v[0]), .wp4(wp_v[4]), .rp4(rp_v[4]), .rq0(rq_v[0])
);

// File: tb/line_delay_mem_bench.sv
`timescale 1ns/1ps
module line_delay_mem_bench;
  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] mode;
  logic wrst_a, wen_a, rrst_a, ren_a, oe_a, q_a_on;
  logic wrst_b, wen_b, rrst_b, ren_b, oe_b, q_b_on;
  logic wrst_c, wen_c, rrst_c, ren_c, oe_c;
  logic [DW-1:0] din_a, din_b, din_c, q_a, q_b, q_c;
  logic [1:0] q_c_on;

  line_delay_mem #(.DEPTH(DEPTH), .DW(DW)) u_line_delay_mem (
    .mode(mode),
    .wclk_a(clk), .wrst_a(wrst_a), .wen_a(wen_a), .din_a(din_a),
    .rclk_a(clk), .rrst_a(rrst_a), .ren_a(ren_a), .oe_a(oe_a), .q_a(q_a), .q_a_on(q_a_on),
    .wclk_b(clk), .wrst_b(wrst_b), .wen_b(wen_b), .din_b(din_b),
    .rclk_b(clk), .rrst_b(rrst_b), .ren_b(ren_b), .oe_b(oe_b), .q_b(q_b), .q_b_on(q_b_on),
    .wclk_c(clk), .wrst_c(wrst_c), .wen_c(wen_c), .din_c(din_c),
    .rclk_c(clk), .rrst_c(rrst_c), .ren_c(ren_c), .oe_c(oe_c), .q_c(q_c), .q_c_on(q_c_on)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entry: {line length, mode, lane5 .. lane0}; lane code {src[1:0], nibble, delay[1:0]}, delay 0 = hold
  localparam logic [36:0] TBL [6] = '{
    {4'd4, 3'd1, 5'b00000, 5'b00000, 5'b01101, 5'b01001, 5'b00101, 5'b00001},
    {4'd5, 3'd2, 5'b00111, 5'b00011, 5'b00110, 5'b00010, 5'b00101, 5'b00001},
    {4'd4, 3'd3, 5'b00000, 5'b00000, 5'b00110, 5'b00010, 5'b00101, 5'b00001},
    {4'd4, 3'd4, 5'b10101, 5'b10001, 5'b01101, 5'b01001, 5'b00101, 5'b00001},
    {4'd3, 3'd5, 5'b10101, 5'b10110, 5'b00110, 5'b00010, 5'b00101, 5'b00001},
    {4'd4, 3'd0, 5'b00000, 5'b00000, 5'b01101, 5'b01001, 5'b00101, 5'b00001}
  };

  function automatic logic [7:0] xw(input int ch, input int m, input int k);
    return {ch[1:0], m[2:0], k[2:0]};
  endfunction

  logic [3:0] lane_q [6];
  assign lane_q[0] = q_a[3:0];
  assign lane_q[1] = q_a[7:4];
  assign lane_q[2] = q_b[3:0];
  assign lane_q[3] = q_b[7:4];
  assign lane_q[4] = q_c[3:0];
  assign lane_q[5] = q_c[7:4];

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all_reset();
    wrst_a = 1; rrst_a = 1; wrst_b = 1; rrst_b = 1; wrst_c = 1; rrst_c = 1;
    wen_a = 0; ren_a = 0; wen_b = 0; ren_b = 0; wen_c = 0; ren_c = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [3:0] held [6];
    logic [7:0] prev;
    mode = 3'd1; din_a = '0; din_b = '0; din_c = '0;
    oe_a = 0; oe_b = 0; oe_c = 0;
    all_reset();
    step(); step();

    // R11: reset state with outputs disabled
    chk("R11 q_a off", {4'h0, q_a}, 12'h000);
    chk("R11 q_b off", {4'h0, q_b}, 12'h000);
    chk("R11 q_c off", {4'h0, q_c}, 12'h000);
    chk("R11 flags off", {8'h0, q_a_on, q_b_on, q_c_on}, 12'h000);
    oe_a = 1; #1;
    chk("R11 q_a_on", {11'h0, q_a_on}, 12'h001);

    // table walk
    for (int e = 0; e < 6; e++) begin
      logic [36:0] ent;
      int len;
      logic [2:0] md;
      logic casc_b;
      string tag;
      ent = TBL[e];
      len = int'(ent[36:33]);
      md  = ent[32:30];
      casc_b = (md == 3'd2) || (md == 3'd3) || (md == 3'd5);
      tag = (md == 3'd2) ? "R6" : (md == 3'd3) ? "R7" : (md == 3'd4) ? "R8" :
            (md == 3'd5) ? "R9" : (md == 3'd1) ? "R1" : "R12";
      all_reset();
      mode = md; oe_a = 1; oe_b = 1; oe_c = 1;
      step(); step();
      for (int m = 0; m < 6; m++) begin
        all_reset();
        step();
        for (int k = 0; k < len; k++) begin
          wrst_a = 0; rrst_a = 0; wen_a = 1; ren_a = 1;
          // R10: chained modes drive B pins so that using them would stall B
          wrst_b = casc_b; rrst_b = casc_b; wen_b = !casc_b; ren_b = !casc_b;
          din_a = xw(0, m, k); din_b = xw(1, m, k); din_c = xw(2, m, k);
          step();
          for (int i = 0; i < 6; i++) begin
            logic [4:0] code;
            int dly;
            logic [7:0] src;
            code = ent[i*5 +: 5];
            dly  = int'(code[1:0]);
            if (dly == 0) begin
              if (m == 0 && k == 0) held[i] = lane_q[i];
              else chk($sformatf("%s lane%0d hold", tag, i), {8'h0, lane_q[i]}, {8'h0, held[i]});
            end else if (m >= dly) begin
              src = xw(int'(code[4:3]), m - dly, k);
              chk($sformatf("%s lane%0d m%0d k%0d", (dly >= 2) ? "R10" : tag, i, m, k),
                  {8'h0, lane_q[i]}, {8'h0, code[2] ? src[7:4] : src[3:0]});
            end
          end
        end
      end
    end

    // R11: output enable routing of C halves
    all_reset();
    mode = 3'd4; oe_a = 0; oe_b = 1; oe_c = 1;
    step();
    chk("R11 wide q_c_on", {10'h0, q_c_on}, 12'h001);
    chk("R11 wide q_c hi zero", {8'h0, q_c[7:4]}, 12'h000);
    chk("R11 wide q_a zero", {4'h0, q_a}, 12'h000);
    mode = 3'd1; #1;
    chk("R11 narrow q_c_on", {10'h0, q_c_on}, 12'h003);

    // R2 R3 R5: write past the end with a gap, mode 1 channel A
    oe_a = 1;
    step();
    wrst_a = 1; wen_a = 1; din_a = 8'hEE;
    step();
    wrst_a = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      wen_a = 1; din_a = 8'h40 + 8'(i);
      step();
    end
    wen_a = 0; din_a = 8'hAA;
    step();
    wen_a = 1; din_a = 8'hBB;
    step();
    wen_a = 0;
    prev = q_a;
    rrst_a = 1; ren_a = 1;
    step();
    chk("R2 read reset moves no data", {4'h0, q_a}, {4'h0, prev});
    rrst_a = 0;
    step();
    chk("R5 addr0 overwritten after wrap", {4'h0, q_a}, 12'h050);
    step();
    chk("R5 addr1 overwritten after wrap", {4'h0, q_a}, 12'h051);
    step();
    chk("R3 disabled write not stored", {4'h0, q_a}, 12'h0BB);
    ren_a = 0;
    step();
    chk("R4 output holds", {4'h0, q_a}, 12'h0BB);
    step();
    chk("R4 output still holds", {4'h0, q_a}, 12'h0BB);
    ren_a = 1;
    step();
    chk("R4 pointer held across gap", {4'h0, q_a}, 12'h043);

    finish_run();
  end
endmodule